// File: doc/BRIEF.md
# Snooping MESI Write-Invalidate Coherence Controller

This block keeps four private, direct-mapped, one-word-per-line caches coherent over one shared bus. Each processor port issues single-word loads and stores through a level handshake: it holds its request, address and store data until the done pulse arrives, and on a load it takes the read data in that same cycle. A cache that cannot finish an access locally asks for the bus. A round-robin arbiter grants one cache per cycle, and that cache's transaction completes in the cycle it is granted. Every other cache snoops the transaction in the same cycle: it reports that it shares the line, supplies dirty data, or drops its copy. A flat word memory sits behind the bus and always supplies fill data unless a dirty holder supplies it instead.

Each cache runs one controller with three states. `CS_IDLE` waits for a request. A hit that needs no bus message completes from `CS_IDLE` in a cycle when the bus is idle. The transition `IDLE->BUS` is taken on a miss, on a store to a Shared line, or when the victim line is dirty. `CS_BUS` holds the bus request. A granted write-back keeps the controller in `CS_BUS`. A granted fill or invalidate takes the transition `BUS->DONE`. `CS_DONE` raises done for one cycle and then takes `DONE->IDLE`. The bus command is chosen from the line's state at the moment of grant, so snoop traffic seen while waiting is taken into account.

Top module: `snoop_mesi_ctrl`

## Requirements
- R1: After reset no done is raised, the bus command output is idle (code 0), memory reads as zero and every line is Invalid, so the first load of any address causes a bus transaction.
- R2: A load miss that no other cache shares issues a read (code 1) and installs the line Exclusive. A following store to it completes with no bus transaction.
- R3: A load miss that another cache holds installs the line Shared. A store to a Shared line issues an upgrade (code 3) that sets every other copy Invalid, so those caches miss on their next load of the address.
- R4: A load of a line that another cache holds Modified gets its data from that holder. The same transaction also writes the data to memory, and both copies end Shared.
- R5: A store miss issues a read-for-ownership (code 2) that invalidates all other copies. The writer's line ends Modified and holds the store data.
- R6: Replacing a Modified line first issues a write-back (code 4) of the old address and then the fill. Replacing a clean line issues no write-back.
- R7: The arbiter grants at most one cache per cycle in round-robin order. The bus owner output names the granted cache.
- R8: Every load returns the value of the latest store to that address in the order the bus serialized them.
- R9: A load hit in any valid state, and a store hit on an Exclusive or Modified line, completes with no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | N_CPU | Request per processor, held until done |
| cpu_we | input | N_CPU | 1 = store, 0 = load |
| cpu_addr | input | N_CPU*AW | Word address per processor |
| cpu_wdata | input | N_CPU*DW | Store data per processor |
| cpu_done | output | N_CPU | One-cycle completion pulse per processor |
| cpu_rdata | output | N_CPU*DW | Load data, valid with done |
| bus_cmd_o | output | 3 | Bus command this cycle: 0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr_o | output | AW | Address of the bus transaction |
| bus_owner_o | output | $clog2(N_CPU) | Index of the granted cache |

## Verification
The hardest situation to reach is contention: several caches waiting for the bus at once, so that a grant to one cache changes the line state another is about to act on. A store that queued against an Exclusive line may then find its data held Modified elsewhere and must take it over. The bench reaches this by starting requests from all four processors on the same cycle, first loads and then stores to one shared address. From the owner sequence it reads the serialization order, and it predicts the surviving value from the last writer.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        BC_IDLE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPG  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_BUS  = 2'd1,
        CS_DONE = 2'd2
    } cfsm_e;

endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
    parameter int N = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N-1:0]                      req,
    output logic [N-1:0]                      gnt,
    output logic                              gnt_valid,
    output logic [(N > 1 ? $clog2(N) : 1)-1:0] gnt_idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;

    // search starting at the rotating pointer
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_idx   = ptr_q;
        for (int off = 0; off < N; off++) begin
            idx = (int'(ptr_q) + off) % N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(idx);
            end
        end
        gnt = gnt_valid ? (N'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt_valid) begin
            ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
        end
    end

    // R7: never more than one grant
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7: a waiting competitor is served before the same cache again
    a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && ((req & ~gnt) != '0)) |=> (gnt_valid && gnt_idx != $past(gnt_idx)));

endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

endmodule

// File: rtl/coh_cache.sv
module coh_cache
    import coh_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int IDX_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    // processor side
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    // requester side of the bus
    output logic          bus_req,
    input  logic          bus_gnt,
    output bus_cmd_e      req_cmd,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    input  logic          any_shared,
    // snooped bus
    input  bus_cmd_e      bus_cmd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          snp_shared,
    output logic          snp_flush,
    output logic [DW-1:0] snp_data
);
    localparam int TAG_W = AW - IDX_W;
    localparam int LINES = 1 << IDX_W;

    cfsm_e              fsm_q, fsm_d;
    mesi_e              st_q  [LINES];
    logic [TAG_W-1:0]   tag_q [LINES];
    logic [DW-1:0]      dat_q [LINES];
    logic [DW-1:0]      rdata_q;

    logic [IDX_W-1:0]   cidx, sidx;
    logic [TAG_W-1:0]   ctag, stag;
    logic               c_valid, c_match, c_hit, victim_dirty, local_ok, bus_idle;
    logic               s_hit;
    logic               do_local, do_grant;

    // processor lookup
    always_comb begin
        cidx         = cpu_addr[IDX_W-1:0];
        ctag         = cpu_addr[AW-1:IDX_W];
        c_valid      = (st_q[cidx] != ST_I);
        c_match      = (tag_q[cidx] == ctag);
        c_hit        = c_valid && c_match;
        victim_dirty = c_valid && !c_match && (st_q[cidx] == ST_M);
        local_ok     = c_hit && (!cpu_we || st_q[cidx] == ST_E || st_q[cidx] == ST_M);
        bus_idle     = (bus_cmd == BC_IDLE);
    end

    // command chosen from the line state at grant time
    always_comb begin
        if (victim_dirty)   req_cmd = BC_WB;
        else if (!cpu_we)   req_cmd = BC_RD;
        else if (c_hit)     req_cmd = BC_UPG;
        else                req_cmd = BC_RDX;
        req_addr = victim_dirty ? {tag_q[cidx], cidx} : cpu_addr;
        req_data = dat_q[cidx];
    end

    // snoop response
    always_comb begin
        sidx       = bus_addr[IDX_W-1:0];
        stag       = bus_addr[AW-1:IDX_W];
        s_hit      = !bus_gnt && (bus_cmd != BC_IDLE) && (bus_cmd != BC_WB) &&
                     (st_q[sidx] != ST_I) && (tag_q[sidx] == stag);
        snp_shared = s_hit && (bus_cmd == BC_RD);
        snp_flush  = s_hit && (st_q[sidx] == ST_M) &&
                     (bus_cmd == BC_RD || bus_cmd == BC_RDX);
        snp_data   = dat_q[sidx];
    end

    // next state
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            CS_IDLE: begin
                if (cpu_req) begin
                    if (!local_ok)     fsm_d = CS_BUS;
                    else if (bus_idle) fsm_d = CS_DONE;
                end
            end
            CS_BUS:  if (bus_gnt && req_cmd != BC_WB) fsm_d = CS_DONE;
            CS_DONE: fsm_d = CS_IDLE;
            default: fsm_d = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (fsm_q == CS_BUS);
        cpu_done  = (fsm_q == CS_DONE);
        cpu_rdata = rdata_q;
        do_local  = (fsm_q == CS_IDLE) && cpu_req && local_ok && bus_idle;
        do_grant  = (fsm_q == CS_BUS) && bus_gnt;
    end

    // state register and line arrays
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q   <= CS_IDLE;
            rdata_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            fsm_q <= fsm_d;
            if (s_hit) begin
                unique case (bus_cmd)
                    BC_RD:          st_q[sidx] <= ST_S;
                    BC_RDX, BC_UPG: st_q[sidx] <= ST_I;
                    default: ;
                endcase
            end
            if (do_local) begin
                if (cpu_we) begin
                    dat_q[cidx] <= cpu_wdata;
                    st_q[cidx]  <= ST_M;
                    rdata_q     <= cpu_wdata;
                end else begin
                    rdata_q     <= dat_q[cidx];
                end
            end
            if (do_grant) begin
                unique case (req_cmd)
                    BC_WB: st_q[cidx] <= ST_I;
                    BC_RD: begin
                        tag_q[cidx] <= ctag;
                        dat_q[cidx] <= bus_data;
                        st_q[cidx]  <= any_shared ? ST_S : ST_E;
                        rdata_q     <= bus_data;
                    end
                    BC_RDX, BC_UPG: begin
                        tag_q[cidx] <= ctag;
                        dat_q[cidx] <= cpu_wdata;
                        st_q[cidx]  <= ST_M;
                        rdata_q     <= cpu_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: store to an Exclusive line finishes locally on the next cycle
    a_r2_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == CS_IDLE && cpu_req && cpu_we && c_hit && st_q[cidx] == ST_E && bus_idle)
        |=> (fsm_q == CS_DONE));

    // R3: a snooped upgrade or ownership read leaves the copy Invalid
    a_r3_snoop_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hit && (bus_cmd == BC_UPG || bus_cmd == BC_RDX))
        |=> (st_q[$past(sidx)] == ST_I));

    // R4: a snooped read leaves the copy Shared
    a_r4_snoop_share: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hit && bus_cmd == BC_RD) |=> (st_q[$past(sidx)] == ST_S));

    // R6: a write-back is always followed by a further bus request
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (do_grant && req_cmd == BC_WB) |=> (fsm_q == CS_BUS && !victim_dirty));

endmodule

// File: rtl/snoop_mesi_ctrl.sv
module snoop_mesi_ctrl
    import coh_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int IDX_W = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [N_CPU-1:0]                          cpu_req,
    input  logic [N_CPU-1:0]                          cpu_we,
    input  logic [N_CPU*AW-1:0]                       cpu_addr,
    input  logic [N_CPU*DW-1:0]                       cpu_wdata,
    output logic [N_CPU-1:0]                          cpu_done,
    output logic [N_CPU*DW-1:0]                       cpu_rdata,
    output logic [2:0]                                bus_cmd_o,
    output logic [AW-1:0]                             bus_addr_o,
    output logic [(N_CPU > 1 ? $clog2(N_CPU) : 1)-1:0] bus_owner_o
);
    localparam int IW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    logic [N_CPU-1:0] c_req, gnt, c_shared, c_flush;
    bus_cmd_e         c_cmd   [N_CPU];
    logic [AW-1:0]    c_addr  [N_CPU];
    logic [DW-1:0]    c_wb    [N_CPU];
    logic [DW-1:0]    c_sdata [N_CPU];
    logic             gnt_valid;
    logic [IW-1:0]    owner;

    bus_cmd_e         bus_cmd;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_data, mem_rdata, flush_data, mem_wdata;
    logic             flush_any, shared_any, mem_we;

    coh_rr_arbiter #(.N(N_CPU)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (c_req),
        .gnt       (gnt),
        .gnt_valid (gnt_valid),
        .gnt_idx   (owner)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_cache
        coh_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_cache (
            .clk        (clk),
            .rst_n      (rst_n),
            .cpu_req    (cpu_req[g]),
            .cpu_we     (cpu_we[g]),
            .cpu_addr   (cpu_addr[g*AW +: AW]),
            .cpu_wdata  (cpu_wdata[g*DW +: DW]),
            .cpu_done   (cpu_done[g]),
            .cpu_rdata  (cpu_rdata[g*DW +: DW]),
            .bus_req    (c_req[g]),
            .bus_gnt    (gnt[g]),
            .req_cmd    (c_cmd[g]),
            .req_addr   (c_addr[g]),
            .req_data   (c_wb[g]),
            .any_shared (shared_any),
            .bus_cmd    (bus_cmd),
            .bus_addr   (bus_addr),
            .bus_data   (bus_data),
            .snp_shared (c_shared[g]),
            .snp_flush  (c_flush[g]),
            .snp_data   (c_sdata[g])
        );
    end

    // bus multiplexing and snoop combining
    always_comb begin
        bus_cmd    = gnt_valid ? c_cmd[owner] : BC_IDLE;
        bus_addr   = c_addr[owner];
        flush_any  = |c_flush;
        shared_any = |c_shared;
        flush_data = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (c_flush[i]) flush_data = flush_data | c_sdata[i];
        end
        bus_data   = flush_any ? flush_data : mem_rdata;
        mem_we     = (bus_cmd == BC_WB) || flush_any;
        mem_wdata  = (bus_cmd == BC_WB) ? c_wb[owner] : flush_data;
    end

    coh_memory #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (bus_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign bus_cmd_o   = bus_cmd;
    assign bus_addr_o  = bus_addr;
    assign bus_owner_o = owner;

    // R4: a dirty line has one holder, so at most one cache supplies data
    a_r4_single_supplier: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_flush));

    // R4: dirty data is never supplied together with a shared response from another holder
    a_r4_flush_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_any && bus_cmd == BC_RD) |-> ($countones(c_shared) == 1));

    // R7: the bus carries a command only for a granted requester
    a_r7_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BC_IDLE) |-> (c_req[owner] && gnt_valid));

endmodule

// File: tb/test_snoop_mesi_ctrl.sv
`timescale 1ns/1ps
module test_snoop_mesi_ctrl;
    localparam int N = 4, AW = 6, DW = 16, IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    req = '0, we = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdata = '0;
    logic [N-1:0]    done;
    logic [N*DW-1:0] rdata;
    logic [2:0]      bus_cmd;
    logic [AW-1:0]   bus_addr;
    logic [1:0]      bus_owner;

    snoop_mesi_ctrl #(.N_CPU(N), .AW(AW), .DW(DW), .IDX_W(IDX_W)) i_snoop_mesi_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_done(done), .cpu_rdata(rdata),
        .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_owner_o(bus_owner)
    );

    int n_tests = 0, n_fail = 0;
    logic [DW-1:0] ref_mem [64];
    int cnt [5];
    int log_own [64];
    int log_cmd [64];
    int log_n = 0;

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        for (int i = 0; i < 5; i++) cnt[i] = 0;
    end

    // bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && bus_cmd != 3'd0) begin
            if (bus_cmd <= 3'd4) cnt[bus_cmd] = cnt[bus_cmd] + 1;
            if (log_n < 64) begin
                log_own[log_n] = int'(bus_owner);
                log_cmd[log_n] = int'(bus_cmd);
                log_n = log_n + 1;
            end
        end
    end

    task automatic check(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_op(input int c, input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
        @(negedge clk);
        req[c] = 1'b1;
        we[c]  = w;
        addr[c*AW +: AW]  = a;
        wdata[c*DW +: DW] = d;
        forever begin
            @(negedge clk);
            if (done[c]) break;
        end
        rd = rdata[c*DW +: DW];
        req[c] = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  c;
        logic        w;
        logic [5:0]  a;
        logic [15:0] d;
        logic [3:0]  e;   // expected counts {read, rfo, upgrade, write-back}
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 6'h04, 16'h0000, 4'b1000, 4'd2},  // R2 lone read -> Exclusive
        '{2'd0, 1'b1, 6'h04, 16'h1111, 4'b0000, 4'd2},  // R2 silent E->M store
        '{2'd1, 1'b0, 6'h04, 16'h0000, 4'b1000, 4'd4},  // R4 dirty holder supplies
        '{2'd1, 1'b1, 6'h04, 16'h2222, 4'b0010, 4'd4},  // R4 both Shared -> upgrade
        '{2'd0, 1'b0, 6'h04, 16'h0000, 4'b1000, 4'd3},  // R3 invalidated copy misses
        '{2'd2, 1'b0, 6'h04, 16'h0000, 4'b1000, 4'd3},  // R3 installs Shared
        '{2'd2, 1'b1, 6'h04, 16'h3333, 4'b0010, 4'd3},  // R3 Shared store upgrades
        '{2'd3, 1'b1, 6'h08, 16'h4444, 4'b0100, 4'd5},  // R5 store miss
        '{2'd3, 1'b1, 6'h0C, 16'h5555, 4'b0101, 4'd6},  // R6 dirty eviction
        '{2'd0, 1'b0, 6'h08, 16'h0000, 4'b1000, 4'd6},  // R6 written-back value visible
        '{2'd0, 1'b1, 6'h08, 16'h6666, 4'b0000, 4'd2},  // R2 silent store again
        '{2'd1, 1'b0, 6'h09, 16'h0000, 4'b1000, 4'd1},  // R1 memory resets to zero
        '{2'd3, 1'b0, 6'h04, 16'h0000, 4'b1001, 4'd4},  // R4 wb plus flush from M holder
        '{2'd2, 1'b0, 6'h04, 16'h0000, 4'b0000, 4'd9},  // R9 read hit on Shared
        '{2'd1, 1'b1, 6'h05, 16'h7777, 4'b0100, 4'd6},  // R6 clean eviction, no wb
        '{2'd0, 1'b0, 6'h0C, 16'h0000, 4'b1001, 4'd6},  // R6 dirty eviction on read
        '{2'd1, 1'b0, 6'h05, 16'h0000, 4'b0000, 4'd9},  // R9 read hit on Modified
        '{2'd2, 1'b0, 6'h08, 16'h0000, 4'b1000, 4'd8}   // R8 latest value
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] r0, r1, r2, r3, rv;
        int s [5];
        int lb, last;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 done during reset", int'(done), 0);
        check("R1 bus idle during reset", int'(bus_cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 bus idle after reset", int'(bus_cmd), 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            for (int j = 0; j < 5; j++) s[j] = cnt[j];
            do_op(int'(VEC[k].c), VEC[k].w, VEC[k].a, VEC[k].d, rv);
            @(negedge clk);
            check($sformatf("R%0d row %0d read count", VEC[k].rq, k), cnt[1] - s[1], int'(VEC[k].e[3]));
            check($sformatf("R%0d row %0d rfo count", VEC[k].rq, k), cnt[2] - s[2], int'(VEC[k].e[2]));
            check($sformatf("R%0d row %0d upgrade count", VEC[k].rq, k), cnt[3] - s[3], int'(VEC[k].e[1]));
            check($sformatf("R%0d row %0d write-back count", VEC[k].rq, k), cnt[4] - s[4], int'(VEC[k].e[0]));
            if (VEC[k].w) ref_mem[VEC[k].a] = VEC[k].d;
            else check($sformatf("R8 row %0d load data (R%0d)", k, VEC[k].rq), int'(rv), int'(ref_mem[VEC[k].a]));
        end

        // R7 four simultaneous load misses
        lb = log_n;
        fork
            do_op(0, 1'b0, 6'h02, 16'h0, r0);
            do_op(1, 1'b0, 6'h06, 16'h0, r1);
            do_op(2, 1'b0, 6'h0A, 16'h0, r2);
            do_op(3, 1'b0, 6'h0E, 16'h0, r3);
        join
        @(negedge clk);
        check("R7 transactions for four loads", log_n - lb, 4);
        for (int k = 0; k < 3; k++)
            check("R7 round-robin order of loads", log_own[lb+k+1], (log_own[lb+k] + 1) % 4);
        check("R8 concurrent load c0", int'(r0), 0);
        check("R8 concurrent load c3", int'(r3), 0);

        // R7 R8 four simultaneous stores to one address
        lb = log_n;
        fork
            do_op(0, 1'b1, 6'h12, 16'hA000, r0);
            do_op(1, 1'b1, 6'h12, 16'hA001, r1);
            do_op(2, 1'b1, 6'h12, 16'hA002, r2);
            do_op(3, 1'b1, 6'h12, 16'hA003, r3);
        join
        @(negedge clk);
        check("R7 transactions for four stores", log_n - lb, 4);
        for (int k = 0; k < 4; k++)
            check("R5 store miss issues rfo", log_cmd[lb+k], 2);
        for (int k = 0; k < 3; k++)
            check("R7 round-robin order of stores", log_own[lb+k+1], (log_own[lb+k] + 1) % 4);
        last = log_own[lb+3];
        ref_mem[6'h12] = 16'hA000 + DW'(last);
        do_op(0, 1'b0, 6'h12, 16'h0, rv);
        check("R8 serialized last writer wins", int'(rv), int'(ref_mem[6'h12]));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule